// File: doc/BRIEF.md
# Programmable Fill-Level Flags for a Dual-Clock FIFO

This block produces the two early-warning fill flags of a FIFO whose write side and read side run on unrelated clocks. The near-empty flag `ae_n` belongs to the read clock domain. The near-full flag `af_n` belongs to the write clock domain. Both flags are active-low. The block keeps the write and read pointers that the surrounding memory uses as addresses. Each side publishes its pointer in Gray code to the other side through a two-flop synchronizer, and the receiving side converts it back to binary before it compares word counts.

The two thresholds are the empty offset X and the full offset Y. Both are captured while the write-side reset is held. `ofs_sel` picks one of three preset values, or it picks programming mode. In programming mode, the first `ofs_load` word after reset becomes X and the next one becomes Y. Until both offsets are known, `ofs_ready` stays low and write requests are refused. The read side asserts `rd_req` when it moves a word into its output register. A word held there therefore no longer counts as stored.

A flag goes active on the clock edge at which its own side changes the level. It goes inactive only after the opposite side's pointer has passed through both synchronizer stages. The memory, the data path and any replay control sit outside this block.

Top module: `fifo_level_flags`

## Requirements
- R1: With n the stored-word count seen by the read side (synchronized write pointer minus read pointer), `ae_n` is 0 while n <= X and 1 while n >= X+1.
- R2: With m the count seen by the write side (write pointer minus synchronized read pointer), `af_n` is 0 while m >= DEPTH-Y and 1 while m <= DEPTH-Y-1. A full memory (m = DEPTH) drives `af_n` to 0.
- R3: After a write edge that brings the memory from X to X+1 words, `ae_n` is still 0 after the first following `rclk` rising edge and is 1 after the second.
- R4: After a read edge that brings the memory from DEPTH-Y to DEPTH-Y-1 words, `af_n` is still 0 after the first following `wclk` rising edge and is 1 after the second.
- R5: A read that lowers the count to X drives `ae_n` to 0 right after that same `rclk` edge. A write that raises the count to DEPTH-Y drives `af_n` to 0 right after that same `wclk` edge.
- R6: If `ofs_sel` is nonzero while `wrst` is high, both X and Y take the preset value (1 -> PRESET_A = 8, 2 -> PRESET_B = 16, 3 -> PRESET_C = 32), and `ofs_ready` is 1 from the first cycle after reset.
- R7: If `ofs_sel` is 0 during reset, `ofs_ready` is 0 after reset. The first cycle with `ofs_load` high loads `ofs_data` into X. The next such cycle loads Y, and it need not be the following cycle. `ofs_ready` then rises, and any later `ofs_load` is ignored.
- R8: While `ofs_ready` is 0, `wr_req` does not advance `wr_ptr`.
- R9: After reset, `wr_ptr` and `rd_ptr` are 0, `ae_n` is 0 and `af_n` is 1.
- R10: A write request is refused while the write-side count equals DEPTH. A read request is refused while the read-side count is 0. `wr_ptr - rd_ptr` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous active-high reset, write side |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous active-high reset, read side |
| ofs_sel | input | 2 | Offset source, sampled during `wrst`: 0 = program, 1/2/3 = preset |
| ofs_load | input | 1 | Offset word strobe on the write side |
| ofs_data | input | AW | Offset value carried by `ofs_load` |
| wr_req | input | 1 | Request to store one word |
| rd_req | input | 1 | Request to move one word to the output register |
| ofs_ready | output | 1 | Both offsets are known and writes are accepted |
| wr_ptr | output | AW+1 | Binary write pointer; the low AW bits address the memory |
| rd_ptr | output | AW+1 | Binary read pointer; the low AW bits address the memory |
| ae_n | output | 1 | Near-empty flag, active low, `rclk` domain |
| af_n | output | 1 | Near-full flag, active low, `wclk` domain |

## Verification
On a single `rclk` edge, a local read can change the read pointer while a write made earlier on the other clock arrives at the synchronizer's second stage. `ae_n` then has to reflect both changes together. The same kind of overlap happens on `wclk` for `af_n`. The bench provokes these overlaps with random request streams on two clocks whose edges drift against each other, so both kinds of change keep landing on the same edge. A bench model that delays each pointer by two edges of the receiving clock judges every flag and pointer in every cycle. Directed cases pin down the exact edges of R3 to R5.

// File: rtl/flagfifo_pkg.sv
package flagfifo_pkg;
  typedef enum logic [1:0] {
    LD_FIRST = 2'd0,
    LD_SECOND = 2'd1,
    LD_DONE = 2'd2
  } ofs_state_e;

  localparam logic [1:0] SEL_PROGRAM = 2'd0;
endpackage

// File: rtl/flagfifo_offsets.sv
module flagfifo_offsets
  import flagfifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int PRESET_A = 8,
  parameter int PRESET_B = 16,
  parameter int PRESET_C = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    sel,
  input  logic          load,
  input  logic [AW-1:0] data,
  output logic [AW-1:0] x_q,
  output logic [AW-1:0] y_q,
  output logic          ready
);
  ofs_state_e st_q;
  logic [AW-1:0] preset;

  always_comb begin
    case (sel)
      2'd1:    preset = AW'(PRESET_A);
      2'd2:    preset = AW'(PRESET_B);
      2'd3:    preset = AW'(PRESET_C);
      default: preset = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q  <= preset;
      y_q  <= preset;
      st_q <= (sel == SEL_PROGRAM) ? LD_FIRST : LD_DONE;
    end else begin
      case (st_q)
        LD_FIRST:  if (load) begin x_q <= data; st_q <= LD_SECOND; end
        LD_SECOND: if (load) begin y_q <= data; st_q <= LD_DONE; end
        default:   st_q <= LD_DONE;
      endcase
    end
  end

  assign ready = (st_q == LD_DONE);

  AST_OFS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ready |=> ($stable(x_q) && $stable(y_q))); // R7
endmodule

// File: rtl/flagfifo_ptr.sv
module flagfifo_ptr #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q
);
  logic [PW-1:0] nxt;
  assign nxt = bin_q + PW'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= nxt;
      gray_q <= nxt ^ (nxt >> 1);
    end
  end
endmodule

// File: rtl/flagfifo_sync.sv
module flagfifo_sync #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH = 64,
  parameter int PRESET_A = 8,
  parameter int PRESET_B = 16,
  parameter int PRESET_C = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          rclk,
  input  logic          rrst,
  input  logic [1:0]    ofs_sel,
  input  logic          ofs_load,
  input  logic [AW-1:0] ofs_data,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          ofs_ready,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          ae_n,
  output logic          af_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [AW-1:0] x_q, y_q;
  logic [PW-1:0] wgray, rgray, wbin_at_r, rbin_at_w;
  logic [PW-1:0] cnt_w, cnt_r, af_thr;
  logic          wr_fire, rd_fire;

  // Offsets live on the write side. They are static before the first write is allowed.
  flagfifo_offsets #(.AW(AW), .PRESET_A(PRESET_A), .PRESET_B(PRESET_B), .PRESET_C(PRESET_C))
    u_ofs (.clk(wclk), .rst(wrst), .sel(ofs_sel), .load(ofs_load), .data(ofs_data),
           .x_q(x_q), .y_q(y_q), .ready(ofs_ready));

  // ---------------- write side ----------------
  assign cnt_w   = wr_ptr - rbin_at_w;
  assign wr_fire = wr_req && ofs_ready && (cnt_w != DEPTH_P);
  assign af_thr  = DEPTH_P - {1'b0, y_q};
  assign af_n    = (cnt_w < af_thr);

  flagfifo_ptr #(.PW(PW)) u_wptr (.clk(wclk), .rst(wrst), .inc(wr_fire),
                                  .bin_q(wr_ptr), .gray_q(wgray));
  flagfifo_sync #(.PW(PW)) u_rsync (.clk(wclk), .rst(wrst), .gray_i(rgray), .bin_o(rbin_at_w));

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (wrst)
    cnt_w <= DEPTH_P); // R10
  AST_NO_WRITE_EARLY: assert property (@(posedge wclk) disable iff (wrst)
    !ofs_ready |=> $stable(wr_ptr)); // R8
  AST_AF_CLEAR_BY_SYNC: assert property (@(posedge wclk) disable iff (wrst)
    $rose(af_n) |-> !$stable(rbin_at_w)); // R4
  AST_AF_SET_BY_WRITE: assert property (@(posedge wclk) disable iff (wrst)
    $fell(af_n) |-> !$stable(wr_ptr)); // R5

  // ---------------- read side ----------------
  assign cnt_r   = wbin_at_r - rd_ptr;
  assign rd_fire = rd_req && (cnt_r != '0);
  assign ae_n    = (cnt_r > {1'b0, x_q});

  flagfifo_ptr #(.PW(PW)) u_rptr (.clk(rclk), .rst(rrst), .inc(rd_fire),
                                  .bin_q(rd_ptr), .gray_q(rgray));
  flagfifo_sync #(.PW(PW)) u_wsync (.clk(rclk), .rst(rrst), .gray_i(wgray), .bin_o(wbin_at_r));

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rrst)
    cnt_r <= DEPTH_P); // R10
  AST_AE_CLEAR_BY_SYNC: assert property (@(posedge rclk) disable iff (rrst)
    $rose(ae_n) |-> !$stable(wbin_at_r)); // R3
  AST_AE_SET_BY_READ: assert property (@(posedge rclk) disable iff (rrst)
    $fell(ae_n) |-> !$stable(rd_ptr)); // R5
endmodule

// File: tb/fifo_level_flags_tb.sv
`timescale 1ns/100ps
module fifo_level_flags_tb;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DP = PW'(DEPTH);

  logic wclk, rclk, wrst, rrst;
  logic [1:0] ofs_sel;
  logic ofs_load, wr_req, rd_req;
  logic [AW-1:0] ofs_data;
  logic ofs_ready, ae_n, af_n;
  logic [PW-1:0] wr_ptr, rd_ptr;

  int n_tests = 0, n_fail = 0;
  bit chk_en = 0;

  fifo_level_flags #(.DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst), .ofs_sel(ofs_sel),
    .ofs_load(ofs_load), .ofs_data(ofs_data), .wr_req(wr_req), .rd_req(rd_req),
    .ofs_ready(ofs_ready), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ae_n(ae_n), .af_n(af_n));

  // write clock 200 MHz; read clock 7 ns, its edges never coincide with wclk rising edges
  initial begin wclk = 0; forever #2.5 wclk = ~wclk; end
  initial begin rclk = 0; #1 rclk = 1; forever #3.5 rclk = ~rclk; end

  task automatic chk(string req, int act, int exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- bench reference model ----------------
  logic [PW-1:0] m_wptr, m_rptr, m_ws1, m_ws2, m_rs1, m_rs2;
  logic [AW-1:0] m_x, m_y;
  int m_ld;

  function automatic logic [AW-1:0] preset_of(logic [1:0] s);
    case (s)
      2'd1: return AW'(8);
      2'd2: return AW'(16);
      2'd3: return AW'(32);
      default: return '0;
    endcase
  endfunction
  function automatic bit exp_ae(logic [PW-1:0] ws, logic [PW-1:0] rp, logic [AW-1:0] x);
    logic [PW-1:0] n = ws - rp;
    return n > {1'b0, x};
  endfunction
  function automatic bit exp_af(logic [PW-1:0] wp, logic [PW-1:0] rs, logic [AW-1:0] y);
    logic [PW-1:0] m = wp - rs;
    return m < (DP - {1'b0, y});
  endfunction

  always @(posedge wclk) begin
    if (wrst) begin
      m_wptr <= '0; m_rs1 <= '0; m_rs2 <= '0;
      m_x <= preset_of(ofs_sel); m_y <= preset_of(ofs_sel);
      m_ld <= (ofs_sel == 2'd0) ? 0 : 2;
    end else begin
      if (ofs_load && m_ld == 0) begin m_x <= ofs_data; m_ld <= 1; end
      if (ofs_load && m_ld == 1) begin m_y <= ofs_data; m_ld <= 2; end
      if (wr_req && m_ld == 2 && (m_wptr - m_rs2) != DP) m_wptr <= m_wptr + 1'b1;
      m_rs1 <= m_rptr; m_rs2 <= m_rs1;
    end
  end
  always @(posedge rclk) begin
    if (rrst) begin
      m_rptr <= '0; m_ws1 <= '0; m_ws2 <= '0;
    end else begin
      if (rd_req && (m_ws2 - m_rptr) != '0) m_rptr <= m_rptr + 1'b1;
      m_ws1 <= m_wptr; m_ws2 <= m_ws1;
    end
  end

  // cycle-by-cycle comparison, away from the active edges
  always @(negedge wclk) if (chk_en && !wrst && !rrst) begin
    chk("R2", af_n, exp_af(m_wptr, m_rs2, m_y), "af_n vs model");
    chk("R8", wr_ptr, m_wptr, "wr_ptr vs model (R10 guard)");
    chk("R7", ofs_ready, (m_ld == 2), "ofs_ready vs model");
  end
  always @(negedge rclk) if (chk_en && !wrst && !rrst) begin
    chk("R1", ae_n, exp_ae(m_ws2, m_rptr, m_x), "ae_n vs model");
    chk("R10", rd_ptr, m_rptr, "rd_ptr vs model");
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset(logic [1:0] s);
    chk_en = 0;
    wrst = 1; rrst = 1; ofs_sel = s; wr_req = 0; rd_req = 0; ofs_load = 0; ofs_data = '0;
    repeat (4) @(negedge rclk);
    @(negedge wclk) wrst = 0;
    @(negedge rclk) rrst = 0;
    chk_en = 1;
  endtask
  task automatic writes(int n);
    if (n > 0) begin
      @(negedge wclk) wr_req = 1;
      repeat (n) @(negedge wclk);
      wr_req = 0;
    end
  endtask
  task automatic reads(int n);
    if (n > 0) begin
      @(negedge rclk) rd_req = 1;
      repeat (n) @(negedge rclk);
      rd_req = 0;
    end
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge wclk);
  endtask
  task automatic load_word(logic [AW-1:0] v);
    @(negedge wclk) begin ofs_load = 1; ofs_data = v; end
    @(negedge wclk) ofs_load = 0;
  endtask
  task automatic random_traffic(int cycles, int wpct, int rpct);
    fork
      begin
        for (int i = 0; i < cycles; i++) begin
          @(negedge wclk) wr_req = ($urandom_range(99) < wpct);
        end
        wr_req = 0;
      end
      begin
        for (int i = 0; i < (cycles * 5) / 7; i++) begin
          @(negedge rclk) rd_req = ($urandom_range(99) < rpct);
        end
        rd_req = 0;
      end
    join
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    wrst = 1; rrst = 1; ofs_sel = 2'd1; wr_req = 0; rd_req = 0; ofs_load = 0; ofs_data = '0;

    // ---- preset 8/8 ----
    do_reset(2'd1);
    @(negedge wclk);
    chk("R9", ae_n, 0, "ae_n after reset");
    chk("R9", af_n, 1, "af_n after reset");
    chk("R9", wr_ptr, 0, "wr_ptr after reset");
    chk("R9", rd_ptr, 0, "rd_ptr after reset");
    chk("R6", ofs_ready, 1, "ready with preset");

    writes(8); idle(8);
    chk("R1", ae_n, 0, "ae_n at X words");
    // R3: one write takes count to X+1
    @(negedge wclk) wr_req = 1;
    @(posedge wclk); wr_req <= 0;
    @(posedge rclk); @(negedge rclk);
    chk("R3", ae_n, 0, "ae_n after first rclk edge");
    @(posedge rclk); @(negedge rclk);
    chk("R3", ae_n, 1, "ae_n after second rclk edge");
    // R5: one read back to X
    @(negedge rclk) rd_req = 1;
    @(posedge rclk); rd_req <= 0;
    @(negedge rclk);
    chk("R5", ae_n, 0, "ae_n right after read to X");

    writes(47); idle(8);
    chk("R2", af_n, 1, "af_n at DEPTH-Y-1");
    @(negedge wclk) wr_req = 1;
    @(posedge wclk); wr_req <= 0;
    @(negedge wclk);
    chk("R5", af_n, 0, "af_n right after write to DEPTH-Y");
    idle(4);
    // R4: one read back to DEPTH-Y-1
    @(negedge rclk) rd_req = 1;
    @(posedge rclk); rd_req <= 0;
    @(posedge wclk); @(negedge wclk);
    chk("R4", af_n, 0, "af_n after first wclk edge");
    @(posedge wclk); @(negedge wclk);
    chk("R4", af_n, 1, "af_n after second wclk edge");

    writes(20); idle(8);
    chk("R10", wr_ptr - rd_ptr, DEPTH, "count capped at DEPTH");
    chk("R2", af_n, 0, "af_n when full");
    reads(80); idle(8);
    chk("R10", rd_ptr, wr_ptr, "reads stop at empty");
    chk("R1", ae_n, 0, "ae_n when empty");

    // ---- programmed offsets ----
    do_reset(2'd0);
    @(negedge wclk);
    chk("R7", ofs_ready, 0, "not ready in program mode");
    writes(3); idle(6);
    chk("R8", wr_ptr, 0, "writes refused before offsets");
    load_word(AW'(3)); idle(3); load_word(AW'(5));
    chk("R7", ofs_ready, 1, "ready after two words");
    load_word(AW'(40));
    writes(3); idle(8);
    chk("R7", ae_n, 0, "ae_n at X=3");
    writes(1); idle(8);
    chk("R7", ae_n, 1, "ae_n at 4 words");
    writes(54); idle(8);
    chk("R7", af_n, 1, "af_n at 58 with Y=5");
    writes(1); idle(8);
    chk("R7", af_n, 0, "af_n at 59 with Y=5, late load ignored");
    reads(1); idle(8);
    chk("R2", af_n, 1, "af_n back high at 58");

    // ---- random traffic, preset 16/16 ----
    do_reset(2'd2);
    random_traffic(3000, 60, 40);
    random_traffic(3000, 35, 70);
    idle(10);
    // ---- random traffic, random programmed offsets ----
    do_reset(2'd0);
    load_word(AW'($urandom_range(1, 30)));
    load_word(AW'($urandom_range(1, 30)));
    random_traffic(3000, 55, 50);
    random_traffic(2000, 80, 30);
    random_traffic(2000, 20, 90);
    idle(10);
    chk_en = 0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule